// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Interface Controller

This block is a full-duplex serial peripheral interface engine. It can drive the bus as master or answer on it as slave. Every serial clock cycle moves one bit out and one bit in, most significant bit first. The serial clock idles low. Data changes on the falling edge and is sampled on the rising edge. The host side has two independent FIFOs. A single-cycle write strobe pushes a word into the transmit FIFO, and a single-cycle read strobe pops the receive FIFO into a registered read-data port. A CPU or a DMA agent can serve either FIFO without waiting on the other.

In master mode the block divides the system clock to make the serial clock and drives an active-low select. Back-to-back words are sent under one select assertion as long as the transmit FIFO has data. In slave mode the incoming clock, select and data pass through two-flop synchronizers, and edges are detected in the system clock domain. This requires the system clock to run at least four times the serial clock. Each pin's direction follows the role. When the block is disabled, every output enable is released so the pads can serve as general-purpose I/O.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: With `en`=1 and `master`=1, `sck_oe`, `ss_oe` and `mosi_oe` are 1 and `miso_oe` is 0. With `en`=1 and `master`=0, those three are 0, and `miso_oe` is 1 only while the synchronized `ss_n_i` is low.
- R2: While `en`=0 every output enable is 0 one cycle later, `rx_overrun` is cleared, and no transfer runs. FIFO contents are kept.
- R3: In master mode `sck_o` idles low. Each half period lasts `div` system clocks, and a `div` of 0 counts as 1. Consecutive rising edges of `sck_o` are therefore 2·max(div,1) cycles apart, including across word boundaries.
- R4: Words are shifted MSB first. `mosi_o`/`miso_o` change only after a falling edge or at the start of a word, and the partner samples on the rising edge.
- R5: In master mode `ss_n_o` goes low one half period before the first rising edge and stays low across back-to-back words. It goes high after the final falling edge when the transmit FIFO is empty. No clock runs while the transmit FIFO is empty.
- R6: Transmit and receive run together. After each W rising edges, the W sampled bits are pushed to the receive FIFO as one word, with the first sampled bit in the MSB.
- R7: A `tx_wr` pulse pushes `tx_wdata`. A write while `tx_full` is 1 is dropped. `tx_level` counts stored words, and `tx_empty`/`tx_full` mark 0 and DEPTH.
- R8: An `rx_rd` pulse pops the receive FIFO, and the word appears on `rx_rdata` the next cycle. A read while `rx_empty` is 1 changes nothing.
- R9: A received word that arrives while the receive FIFO is full is discarded and sets `rx_overrun`, which stays set until `en` falls.
- R10: In slave mode, clock edges while `ss_n_i` is high are ignored. A falling `ss_n_i` loads the next transmit word, or zeros when the FIFO is empty. A new word is loaded after every W-th falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| master | input | 1 | 1 = master role, 0 = slave role |
| div | input | DIVW | Half serial period in system clocks (0 acts as 1) |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_wdata | input | W | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | $clog2(DEPTH)+1 | Transmit FIFO fill level |
| rx_rd | input | 1 | Receive data read strobe |
| rx_rdata | output | W | Last popped receive word |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | $clog2(DEPTH)+1 | Receive FIFO fill level |
| rx_overrun | output | 1 | Sticky lost-word flag |
| sck_i | input | 1 | Serial clock pad input |
| sck_o | output | 1 | Serial clock pad output |
| sck_oe | output | 1 | Serial clock output enable |
| ss_n_i | input | 1 | Select pad input |
| ss_n_o | output | 1 | Select pad output |
| ss_oe | output | 1 | Select output enable |
| mosi_i | input | 1 | Master-out pad input |
| mosi_o | output | 1 | Master-out pad output |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in pad input |
| miso_o | output | 1 | Master-in pad output |
| miso_oe | output | 1 | Master-in output enable |

## Verification
The bench builds the block with W=8, DEPTH=4 and DIVW=4. A four-entry FIFO fills in a handful of words, so the full, overrun and dropped-write boundaries are reached in short runs. With a four-bit divider, the bench can sweep every half-period setting from 0 to 4 and compute the expected rising-edge spacing and data for each. A behavioural partner answers each master word with the word XOR 0x5A. In slave mode the bench drives the serial clock at sixteen system clocks per period, which keeps the synchronizer margin.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    MS_IDLE,
    MS_LOW,
    MS_HIGH
  } sdc_mst_e;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= RSTV;
      else if (g == 0) stg[g] <= d;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdc_fifo.sv
module sdc_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [W-1:0]             wdata,
  input  logic                     pop,
  output logic [W-1:0]             head,
  output logic                     full,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_push, do_pop;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign level   = wptr - rptr;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
    end
  end

  // R7: a push into a full FIFO leaves the count unchanged
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop |=> full && (level == $past(level)));
  // R8: a pop from an empty FIFO leaves it empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push |=> empty);
endmodule

// File: rtl/sdc_engine.sv
module sdc_engine
  import sdc_pkg::*;
#(
  parameter int W = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            master,
  input  logic [DIVW-1:0] div,
  input  logic [W-1:0]    tx_head,
  input  logic            tx_empty,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [W-1:0]    rx_word,
  input  logic            sck_s,
  input  logic            ss_s,
  input  logic            mosi_s,
  input  logic            miso_in,
  output logic            sck_o,
  output logic            ss_n_o,
  output logic            sdata
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] LASTB = BW'(W-1);

  sdc_mst_e        st;
  logic [W-1:0]    sh, rsh;
  logic [BW-1:0]   bitcnt;
  logic [DIVW-1:0] cnt, last_cnt;
  logic            sck_d, ss_d;
  logic            m_on, s_on, s_rise, s_fall, ss_fall, half_done;

  assign m_on      = en && master;
  assign s_on      = en && !master;
  assign last_cnt  = (div == '0) ? '0 : div - 1'b1;
  assign half_done = (cnt == last_cnt);
  assign s_rise    = s_on && !ss_s && sck_s && !sck_d;
  assign s_fall    = s_on && !ss_s && !sck_s && sck_d;
  assign ss_fall   = s_on && !ss_s && ss_d;
  assign sdata     = sh[W-1];

  always_comb begin
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    rx_word = rsh;
    if (m_on) begin
      if (st == MS_IDLE && !tx_empty) tx_pop = 1'b1;
      if (st == MS_HIGH && half_done && bitcnt == LASTB) begin
        rx_push = 1'b1;
        tx_pop  = !tx_empty;
      end
    end else if (s_on) begin
      if ((ss_fall || (s_fall && bitcnt == '0)) && !tx_empty) tx_pop = 1'b1;
      if (s_rise && bitcnt == LASTB) begin
        rx_push = 1'b1;
        rx_word = {rsh[W-2:0], mosi_s};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st     <= MS_IDLE;
      sh     <= '0;
      rsh    <= '0;
      bitcnt <= '0;
      cnt    <= '0;
      sck_o  <= 1'b0;
      ss_n_o <= 1'b1;
      sck_d  <= 1'b0;
      ss_d   <= 1'b1;
    end else begin
      sck_d <= sck_s;
      ss_d  <= ss_s;
      if (master) begin
        case (st)
          MS_IDLE: if (!tx_empty) begin
            sh     <= tx_head;
            ss_n_o <= 1'b0;
            cnt    <= '0;
            bitcnt <= '0;
            st     <= MS_LOW;
          end
          MS_LOW: if (half_done) begin
            cnt   <= '0;
            sck_o <= 1'b1;
            rsh   <= {rsh[W-2:0], miso_in};
            st    <= MS_HIGH;
          end else cnt <= cnt + 1'b1;
          MS_HIGH: if (half_done) begin
            cnt   <= '0;
            sck_o <= 1'b0;
            if (bitcnt == LASTB) begin
              bitcnt <= '0;
              if (!tx_empty) begin
                sh <= tx_head;
                st <= MS_LOW;
              end else begin
                ss_n_o <= 1'b1;
                st     <= MS_IDLE;
              end
            end else begin
              sh     <= sh << 1;
              bitcnt <= bitcnt + 1'b1;
              st     <= MS_LOW;
            end
          end else cnt <= cnt + 1'b1;
          default: st <= MS_IDLE;
        endcase
      end else begin
        if (ss_s) bitcnt <= '0;
        else if (ss_fall) begin
          sh     <= tx_empty ? '0 : tx_head;
          bitcnt <= '0;
        end else begin
          if (s_rise) begin
            rsh    <= {rsh[W-2:0], mosi_s};
            bitcnt <= (bitcnt == LASTB) ? '0 : bitcnt + 1'b1;
          end
          if (s_fall) begin
            if (bitcnt == '0) sh <= tx_empty ? '0 : tx_head;
            else sh <= sh << 1;
          end
        end
      end
    end
  end

  // R5: select is already low whenever the master clock rises
  p_ss_before_clk_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> !ss_n_o);
  // R3: the clock rests low while select is high
  p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    ss_n_o |-> !sck_o);
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  parameter int DIVW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       master,
  input  logic [DIVW-1:0]            div,
  input  logic                       tx_wr,
  input  logic [W-1:0]               tx_wdata,
  output logic                       tx_full,
  output logic                       tx_empty,
  output logic [$clog2(DEPTH):0]     tx_level,
  input  logic                       rx_rd,
  output logic [W-1:0]               rx_rdata,
  output logic                       rx_full,
  output logic                       rx_empty,
  output logic [$clog2(DEPTH):0]     rx_level,
  output logic                       rx_overrun,
  input  logic                       sck_i,
  output logic                       sck_o,
  output logic                       sck_oe,
  input  logic                       ss_n_i,
  output logic                       ss_n_o,
  output logic                       ss_oe,
  input  logic                       mosi_i,
  output logic                       mosi_o,
  output logic                       mosi_oe,
  input  logic                       miso_i,
  output logic                       miso_o,
  output logic                       miso_oe
);
  logic [W-1:0] tx_head, rx_head, rx_word;
  logic         tx_pop, rx_push, sdata;
  logic [2:0]   pin_s;

  sdc_sync #(.N(3), .STAGES(2), .RSTV(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sck_i, ss_n_i, mosi_i}), .q(pin_s)
  );

  sdc_fifo #(.W(W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst), .push(tx_wr), .wdata(tx_wdata), .pop(tx_pop),
    .head(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level)
  );

  sdc_fifo #(.W(W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_word), .pop(rx_rd),
    .head(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level)
  );

  sdc_engine #(.W(W), .DIVW(DIVW)) u_eng (
    .clk(clk), .rst(rst), .en(en), .master(master), .div(div),
    .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word),
    .sck_s(pin_s[2]), .ss_s(pin_s[1]), .mosi_s(pin_s[0]), .miso_in(miso_i),
    .sck_o(sck_o), .ss_n_o(ss_n_o), .sdata(sdata)
  );

  assign mosi_o = sdata;
  assign miso_o = sdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe     <= 1'b0;
      ss_oe      <= 1'b0;
      mosi_oe    <= 1'b0;
      miso_oe    <= 1'b0;
      rx_rdata   <= '0;
      rx_overrun <= 1'b0;
    end else begin
      sck_oe  <= en && master;
      ss_oe   <= en && master;
      mosi_oe <= en && master;
      miso_oe <= en && !master && !pin_s[1];
      if (rx_rd && !rx_empty) rx_rdata <= rx_head;
      if (!en) rx_overrun <= 1'b0;
      else if (rx_push && rx_full) rx_overrun <= 1'b1;
    end
  end

  // R2: disabling releases every pad one cycle later
  p_pins_off_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(sck_oe || ss_oe || mosi_oe || miso_oe));
  // R9: a word arriving at a full receive FIFO raises the overrun flag
  p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
    rx_push && rx_full |=> rx_overrun);
  // R1: the data pins never drive in opposite roles together
  p_miso_dir_r1: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> !(mosi_oe || sck_oe));
endmodule

// File: tb/spi_duplex_ctrl_test.sv
`timescale 1ns/1ps
module spi_duplex_ctrl_test;
  localparam int W = 8, DEPTH = 4, DIVW = 4;

  logic clk = 0, rst = 1, en = 0, master = 0, tx_wr = 0, rx_rd = 0;
  logic [DIVW-1:0] div = 0;
  logic [W-1:0] tx_wdata = 0, rx_rdata;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_overrun;
  logic [2:0] tx_level, rx_level;
  logic sck_i = 0, ss_n_i = 1, mosi_i = 0, miso_i;
  logic sck_o, sck_oe, ss_n_o, ss_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int checks = 0, fails = 0, cyc = 0, lastc = 0, badp = 0, dv = 1;
  int widx = 0, cidx = 0, rcnt = 0, ssr = 0, rises = 0;
  bit first = 1, done = 0;
  logic [7:0] txw [0:15];
  logic [7:0] capw [0:15];
  logic [7:0] cap = 0, tbsh = 0, rd, scap;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;
  assign miso_i = tbsh[7];

  spi_duplex_ctrl #(.W(W), .DEPTH(DEPTH), .DIVW(DIVW)) uut (.*);

  // behavioural partner for master mode: answers word ^ 8'h5A
  always @(negedge ss_n_o) if (sck_oe) begin
    rcnt = 0; first = 1; tbsh = txw[widx] ^ 8'h5A;
  end
  always @(posedge ss_n_o) if (sck_oe) ssr++;
  always @(posedge sck_o) if (sck_oe) begin
    rises++;
    if (!first && (cyc - lastc) != 2*dv) badp++;
    first = 0; lastc = cyc;
    cap = {cap[6:0], mosi_o};
    rcnt++;
    if (rcnt == 8) begin capw[cidx] = cap; cidx++; widx++; rcnt = 0; end
  end
  always @(negedge sck_o) if (sck_oe) begin
    if (rcnt == 0) tbsh = txw[widx] ^ 8'h5A; else tbsh = tbsh << 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) tx_wr = 1; tx_wdata = d;
    @(negedge clk) tx_wr = 0;
  endtask

  task automatic rdw(output logic [7:0] d);
    @(negedge clk) rx_rd = 1;
    @(negedge clk) rx_rd = 0; d = rx_rdata;
  endtask

  task automatic wait_idle(input int n);
    int t = 0;
    while (!(cidx >= n && ss_n_o && tx_empty) && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic start_master(input int d);
    @(negedge clk) en = 0; master = 1; div = DIVW'(d);
    dv = (d == 0) ? 1 : d;
    widx = 0; cidx = 0; rcnt = 0; ssr = 0; badp = 0;
    @(negedge clk) en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    @(negedge clk);
    // reset state (R7, R2)
    chk(tx_empty && tx_level == 0, "R7 reset tx", int'(tx_level), 0);
    chk(rx_empty && rx_level == 0, "R8 reset rx", int'(rx_level), 0);
    chk({sck_oe, ss_oe, mosi_oe, miso_oe} == 0, "R2 reset oe", int'({sck_oe, ss_oe, mosi_oe, miso_oe}), 0);

    // R5: enabled master with empty TX stays idle
    start_master(2); rises = 0;
    repeat (30) @(negedge clk);
    chk(rises == 0 && ss_n_o && !sck_o, "R5 stall", rises, 0);
    chk({sck_oe, ss_oe, mosi_oe, miso_oe} == 4'b1110, "R1 master dirs",
        int'({sck_oe, ss_oe, mosi_oe, miso_oe}), 4'b1110);

    // master sweep over every divider setting
    for (int d = 0; d <= 4; d++) begin
      for (int i = 0; i < 4; i++)
        txw[i] = (d == 1) ? ((i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h80 : 8'h01)
                          : 8'((i * 8'h4B) ^ (d * 8'h1D) ^ 8'hC3);
      start_master(d);
      for (int i = 0; i < 4; i++) wr(txw[i]);
      wait_idle(4);
      chk(cidx == 4, "R6 word count", cidx, 4);
      chk(badp == 0, "R3 rise spacing", badp, 0);
      chk(ssr == 1, "R5 select held across words", ssr, 1);
      for (int i = 0; i < 4; i++) begin
        chk(capw[i] == txw[i], "R4 msb-first out", capw[i], txw[i]);
        rdw(rd);
        chk(rd == (txw[i] ^ 8'h5A), "R6 received word", rd, txw[i] ^ 8'h5A);
      end
      chk(rx_empty, "R8 drained", int'(rx_level), 0);
    end

    // R9: overrun on a fifth word
    for (int i = 0; i < 5; i++) txw[i] = 8'(8'h11 * (i + 1));
    start_master(1);
    for (int i = 0; i < 4; i++) wr(txw[i]);
    while (!tx_empty) @(negedge clk);
    wr(txw[4]);
    wait_idle(5);
    chk(rx_level == 4 && rx_full, "R9 level full", int'(rx_level), 4);
    chk(rx_overrun, "R9 overrun set", int'(rx_overrun), 1);
    for (int i = 0; i < 4; i++) begin
      rdw(rd);
      chk(rd == (txw[i] ^ 8'h5A), "R9 kept words", rd, txw[i] ^ 8'h5A);
    end
    chk(rx_empty, "R9 fifth lost", int'(rx_level), 0);
    @(negedge clk) en = 0;
    repeat (2) @(negedge clk);
    chk(!rx_overrun, "R2 overrun cleared", int'(rx_overrun), 0);
    chk({sck_oe, ss_oe, mosi_oe, miso_oe} == 0, "R2 released", int'({sck_oe, ss_oe, mosi_oe, miso_oe}), 0);

    // R7: writes while full are dropped; R8: empty read ignored
    for (int i = 0; i < 6; i++) begin txw[i] = 8'(8'hA0 + i); wr(txw[i]); end
    chk(tx_level == 4 && tx_full, "R7 full level", int'(tx_level), 4);
    rdw(rd);
    chk(rx_empty && rx_level == 0, "R8 empty read", int'(rx_level), 0);
    start_master(1);
    wait_idle(4);
    repeat (20) @(negedge clk);
    chk(cidx == 4, "R7 only four sent", cidx, 4);
    for (int i = 0; i < 4; i++) chk(capw[i] == txw[i], "R7 stored words", capw[i], txw[i]);
    for (int i = 0; i < 4; i++) rdw(rd);

    // slave mode
    @(negedge clk) en = 0; master = 0;
    @(negedge clk) en = 1;
    wr(8'hC5); wr(8'h3A);
    repeat (5) @(negedge clk);
    chk({sck_oe, ss_oe, mosi_oe, miso_oe} == 0, "R1 slave unselected", int'({sck_oe, ss_oe, mosi_oe, miso_oe}), 0);
    for (int b = 0; b < 8; b++) begin
      repeat (8) @(negedge clk) sck_i = 1;
      repeat (8) @(negedge clk) sck_i = 0;
    end
    repeat (6) @(negedge clk);
    chk(rx_level == 0, "R10 ignored while deselected", int'(rx_level), 0);
    @(negedge clk) ss_n_i = 0;
    repeat (8) @(negedge clk);
    chk(miso_oe && !mosi_oe, "R1 slave selected", int'(miso_oe), 1);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] mw;
      mw = 8'(8'h69 + k * 8'h35);
      txw[k] = mw;
      scap = 0;
      for (int b = 0; b < 8; b++) begin
        mosi_i = mw[7-b];
        repeat (8) @(negedge clk);
        scap = {scap[6:0], miso_o};
        sck_i = 1;
        repeat (8) @(negedge clk);
        sck_i = 0;
      end
      capw[k] = scap;
    end
    repeat (8) @(negedge clk) ss_n_i = 1;
    repeat (6) @(negedge clk);
    chk(capw[0] == 8'hC5, "R10 first word", capw[0], 8'hC5);
    chk(capw[1] == 8'h3A, "R10 second word", capw[1], 8'h3A);
    chk(capw[2] == 8'h00, "R10 zeros when empty", capw[2], 0);
    chk(rx_level == 3, "R6 slave rx count", int'(rx_level), 3);
    for (int k = 0; k < 3; k++) begin
      rdw(rd);
      chk(rd == txw[k], "R6 slave received", rd, txw[k]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule